// File: doc/BRIEF.md
# Six-Step Commutation Output Sequencer

The block drives the high-side and low-side gate lines of three motor phases. Firmware writes the pattern for the next step into a shadow register while the current step is still running. A commutation event then copies the shadow into the active pattern, so all six lines change on the same clock. The event comes from a software strobe or from a rising edge on a trigger input. Outputs that rise are held back by a dead-time interval after their complementary line falls.

Alongside the sequencer, a free-running up counter forms the time base. Three compare channels sit on that counter, and their thresholds are preloaded. A high-active fault input forces every gate line to its idle level, which is high, by clearing the output enable. Once the fault has gone, the output enable comes back by itself at the next counter wrap.

A sticky commutation flag records each event. Firmware clears it with a write-one strobe.

Top module: `sixstep_seq`

## Requirements
- R1: During reset `gate_out` is 6'h3F (idle), `out_en` is 0, `cnt` is 0 and `com_flag` is 0.
- R2: `cnt` increments by one every clock and wraps from PERIOD (default 4095) to 0; the clock on which it holds PERIOD is the update event.
- R3: Writing `shadow_d` (with `shadow_we`) never changes the outputs by itself. A commutation event sampled at clock edge E copies the shadow into the active pattern at E. Lines that fall, and lines that rise with an already idle complement, change at edge E+1.
- R4: A commutation event is raised either by `sw_com` high at a clock edge or by `com_trig` being high at an edge after being low at the previous one. Holding `com_trig` high raises no further events.
- R5: Dead time (DEAD = 1 clock). A line whose complementary line is falling in the same transition rises one clock after the other lines, at edge E+2. No line rises while its complement is high or within DEAD clocks of its complement falling.
- R6: While `out_en` is 1, the two lines of a phase are never both high.
- R7: `fault_in` passes through a two-flop synchronizer. A fault that is high before edge F clears `out_en` at edge F+2. While `out_en` is 0, `gate_out` is 6'h3F.
- R8: After the synchronized fault is low, `out_en` is set again at the edge where `cnt` equals PERIOD, and not before.
- R9: `cmp_hit[k]` is high exactly when `cnt` equals the active threshold of channel k. The thresholds reset to 2047, 1023 and 511 for k = 0, 1 and 2. A write through `cmp_we`/`cmp_sel`/`cmp_d` (a `cmp_sel` of 3 is ignored) becomes active only at the next update event or commutation event.
- R10: `com_flag` is set by every commutation event and cleared by `flag_clr`. When both occur on the same clock, the set wins.
- R11: A commutation event with no shadow rewrite since the previous one leaves `gate_out` unchanged.
- R12: Pattern bits are ordered {C low, C high, B low, B high, A low, A high} from bit 5 down to bit 0. The six steps are 6'h09, 6'h18, 6'h12, 6'h06, 6'h24 and 6'h21, and each appears on `gate_out` unaltered once settled.
- R13: A pattern that asks for both lines of a phase drives both lines of that phase low. The other phases are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| shadow_we | input | 1 | Write strobe for the shadow pattern |
| shadow_d | input | 6 | Next-step pattern |
| sw_com | input | 1 | Software commutation strobe |
| com_trig | input | 1 | Hardware commutation trigger, rising edge |
| cmp_we | input | 1 | Compare threshold write strobe |
| cmp_sel | input | 2 | Compare channel select (0..2) |
| cmp_d | input | CNT_W | Compare threshold write data |
| flag_clr | input | 1 | Write-one clear of the commutation flag |
| fault_in | input | 1 | Asynchronous fault, active high |
| gate_out | output | 6 | Gate lines, bit order as in R12 |
| cnt | output | CNT_W | Time-base counter |
| cmp_hit | output | 3 | Compare match per channel |
| com_flag | output | 1 | Sticky commutation flag |
| out_en | output | 1 | Main output enable |

## Verification
The bound checker covers the following on every cycle:
- the counter's step and wrap;
- that the active pattern moves only on an event and then equals the shadow;
- the flag set;
- per-line dead time, and exclusion of both lines of a phase while outputs are enabled;
- idle forcing;
- fault-to-disable latency, and that the enable cannot return before a wrap.

Only the bench's scenarios can show the following:
- the exact edge on which each line of a transition moves, across all 36 step pairs and all 64 raw patterns;
- that a held trigger raises no second event;
- that a threshold write waits for its load event;
- that a repeated event leaves the outputs alone.

// File: rtl/sixstep_seq.sv
module sixstep_seq #(
  parameter int CNT_W    = 12,
  parameter int PERIOD   = 4095,
  parameter int CMP0_RST = 2047,
  parameter int CMP1_RST = 1023,
  parameter int CMP2_RST = 511,
  parameter int DEAD     = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shadow_we,
  input  logic [5:0]       shadow_d,
  input  logic             sw_com,
  input  logic             com_trig,
  input  logic             cmp_we,
  input  logic [1:0]       cmp_sel,
  input  logic [CNT_W-1:0] cmp_d,
  input  logic             flag_clr,
  input  logic             fault_in,
  output logic [5:0]       gate_out,
  output logic [CNT_W-1:0] cnt,
  output logic [2:0]       cmp_hit,
  output logic             com_flag,
  output logic             out_en
);
  localparam int DW = (DEAD < 2) ? 1 : $clog2(DEAD + 1);
  localparam logic [DW-1:0] DMAX = DW'(DEAD);
  localparam logic [CNT_W-1:0] TOP = CNT_W'(PERIOD);

  logic [5:0] shadow, act, req, drv, drv_nxt;
  logic [DW-1:0] lowc [6];
  logic [CNT_W-1:0] cmp_pre [3];
  logic [CNT_W-1:0] cmp_act [3];
  logic trig_q, flt_m, flt_s, upd, com_evt;

  assign upd      = (cnt == TOP);
  assign com_evt  = sw_com | (com_trig & ~trig_q);
  assign gate_out = out_en ? drv : 6'h3F;

  for (genvar p = 0; p < 3; p++) begin : g_phase
    assign req[2*p]   = act[2*p]   & ~act[2*p+1];
    assign req[2*p+1] = act[2*p+1] & ~act[2*p];
  end

  for (genvar i = 0; i < 6; i++) begin : g_line
    assign drv_nxt[i] = req[i] & ~drv[i^1] & ((int'(lowc[i^1]) + 1) >= DEAD);
  end

  for (genvar k = 0; k < 3; k++) begin : g_cmp
    assign cmp_hit[k] = (cnt == cmp_act[k]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      shadow   <= '0;
      act      <= '0;
      drv      <= '0;
      trig_q   <= 1'b0;
      flt_m    <= 1'b0;
      flt_s    <= 1'b0;
      out_en   <= 1'b0;
      com_flag <= 1'b0;
      for (int i = 0; i < 6; i++) lowc[i] <= DMAX;
      cmp_pre[0] <= CNT_W'(CMP0_RST);
      cmp_pre[1] <= CNT_W'(CMP1_RST);
      cmp_pre[2] <= CNT_W'(CMP2_RST);
      cmp_act[0] <= CNT_W'(CMP0_RST);
      cmp_act[1] <= CNT_W'(CMP1_RST);
      cmp_act[2] <= CNT_W'(CMP2_RST);
    end else begin
      cnt    <= upd ? '0 : cnt + 1'b1;
      trig_q <= com_trig;
      flt_m  <= fault_in;
      flt_s  <= flt_m;
      if (flt_s)    out_en <= 1'b0;
      else if (upd) out_en <= 1'b1;
      com_flag <= com_evt | (com_flag & ~flag_clr);
      if (shadow_we) shadow <= shadow_d;
      if (com_evt)   act    <= shadow;
      drv <= drv_nxt;
      for (int i = 0; i < 6; i++)
        lowc[i] <= drv[i] ? '0 : ((lowc[i] == DMAX) ? DMAX : lowc[i] + 1'b1);
      for (int k = 0; k < 3; k++) begin
        if (cmp_we && cmp_sel == 2'(k)) cmp_pre[k] <= cmp_d;
        if (upd || com_evt)             cmp_act[k] <= cmp_pre[k];
      end
    end
  end
endmodule

// File: rtl/sixstep_seq_chk.sv
module sixstep_seq_chk #(
  parameter int CNT_W  = 12,
  parameter int PERIOD = 4095
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt,
  input logic             out_en,
  input logic [5:0]       gate_out,
  input logic [5:0]       drv,
  input logic [5:0]       act,
  input logic [5:0]       shadow,
  input logic             flt_s,
  input logic             com_evt,
  input logic             com_flag
);
  localparam logic [CNT_W-1:0] TOP = CNT_W'(PERIOD);

  p_cnt_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt == TOP |=> cnt == '0);
  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt != TOP |=> cnt == $past(cnt) + 1'b1);
  p_act_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !com_evt |=> $stable(act));
  p_act_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    com_evt |=> act == $past(shadow));
  p_flag_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    com_evt |=> com_flag);
  p_pair_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |-> !(gate_out[0] && gate_out[1]) && !(gate_out[2] && gate_out[3])
               && !(gate_out[4] && gate_out[5]));
  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> gate_out == 6'h3F);
  p_fault_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flt_s |=> !out_en);
  p_no_early_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_en && cnt != TOP) |=> !out_en);

  for (genvar i = 0; i < 6; i++) begin : g_dead
    p_dead_time_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drv[i]) |-> !drv[i^1] && $past(!drv[i^1]));
  end
endmodule

bind sixstep_seq sixstep_seq_chk #(.CNT_W(CNT_W), .PERIOD(PERIOD)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt), .out_en(out_en), .gate_out(gate_out),
  .drv(drv), .act(act), .shadow(shadow), .flt_s(flt_s), .com_evt(com_evt),
  .com_flag(com_flag)
);

// File: tb/tb_sixstep_seq.sv
`timescale 1ns/1ps
module tb_sixstep_seq;
  localparam int W = 12;
  localparam int PER = 4095;

  logic clk = 1'b0, rst_n = 1'b0;
  logic shadow_we = 1'b0, sw_com = 1'b0, com_trig = 1'b0, cmp_we = 1'b0;
  logic flag_clr = 1'b0, fault_in = 1'b0;
  logic [5:0] shadow_d = '0;
  logic [1:0] cmp_sel = '0;
  logic [W-1:0] cmp_d = '0;
  logic [5:0] gate_out;
  logic [W-1:0] cnt;
  logic [2:0] cmp_hit;
  logic com_flag, out_en;
  int nvec = 0, nbad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sixstep_seq dut (
    .clk(clk), .rst_n(rst_n), .shadow_we(shadow_we), .shadow_d(shadow_d),
    .sw_com(sw_com), .com_trig(com_trig), .cmp_we(cmp_we), .cmp_sel(cmp_sel),
    .cmp_d(cmp_d), .flag_clr(flag_clr), .fault_in(fault_in),
    .gate_out(gate_out), .cnt(cnt), .cmp_hit(cmp_hit), .com_flag(com_flag),
    .out_en(out_en)
  );

  task automatic chk(string r, logic [31:0] a, logic [31:0] e);
    nvec++;
    if (a !== e) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", r, a, e);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic logic [5:0] legal(logic [5:0] p);
    logic [5:0] q = p;
    for (int ph = 0; ph < 3; ph++)
      if (p[2*ph] && p[2*ph+1]) begin q[2*ph] = 1'b0; q[2*ph+1] = 1'b0; end
    return q;
  endfunction

  function automatic logic [5:0] step_pat(int s);
    case (s)
      0: return 6'h09;
      1: return 6'h18;
      2: return 6'h12;
      3: return 6'h06;
      4: return 6'h24;
      default: return 6'h21;
    endcase
  endfunction

  function automatic logic excl(logic [5:0] g);
    return !(g[0] && g[1]) && !(g[2] && g[3]) && !(g[4] && g[5]);
  endfunction

  task automatic load(logic [5:0] p);
    shadow_d = p; shadow_we = 1'b1; tick(); shadow_we = 1'b0;
  endtask

  task automatic fire();
    sw_com = 1'b1; tick(); sw_com = 1'b0;
  endtask

  task automatic wait_cnt(int v);
    int n = 0;
    while (cnt != W'(v) && n < 9000) begin tick(); n++; end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] prev;
    logic pen;
    logic [5:0] a, b, swp, e1;
    tick(); tick();
    chk("R1 gate_out", 32'(gate_out), 32'h3F);
    chk("R1 out_en", 32'(out_en), 0);
    chk("R1 cnt", 32'(cnt), 0);
    chk("R1 com_flag", 32'(com_flag), 0);
    rst_n = 1'b1;
    prev = cnt; pen = out_en;
    for (int i = 0; i < 4200; i++) begin
      tick();
      chk("R2 cnt step", 32'(cnt), 32'((int'(prev) + 1) % (PER + 1)));
      chk("R9 reset thresholds", 32'(cmp_hit),
          32'({cnt == W'(511), cnt == W'(1023), cnt == W'(2047)}));
      if (out_en && !pen) chk("R8 enable at wrap", 32'(prev), PER);
      pen = out_en; prev = cnt;
    end
    chk("R8 enabled", 32'(out_en), 1);

    for (int p = 0; p < 64; p++) begin
      load(6'(p));
      chk("R3 shadow write no effect", 32'(gate_out), 0);
      fire();
      chk("R3 no change at E", 32'(gate_out), 0);
      tick();
      chk(legal(6'(p)) == 6'(p) ? "R12 pattern" : "R13 both-set phase off",
          32'(gate_out), 32'(legal(6'(p))));
      tick();
      chk("R3 settled", 32'(gate_out), 32'(legal(6'(p))));
      load(6'h00); fire(); tick(); tick();
    end

    for (int s = 0; s < 6; s++) begin
      for (int t = 0; t < 6; t++) begin
        a = step_pat(s); b = step_pat(t);
        load(a); fire(); tick(); tick(); tick();
        chk("R12 step settled", 32'(gate_out), 32'(a));
        load(b); fire();
        chk("R3 old pattern at E", 32'(gate_out), 32'(a));
        for (int i = 0; i < 6; i++) swp[i] = a[i^1];
        e1 = (a & b) | (b & ~a & ~swp);
        tick();
        chk("R5 first edge", 32'(gate_out), 32'(e1));
        chk("R6 exclusion", 32'(excl(gate_out)), 1);
        tick();
        chk("R5 delayed rise", 32'(gate_out), 32'(b));
      end
    end

    fire(); tick(); tick();
    chk("R11 repeat event", 32'(gate_out), 32'(step_pat(5)));

    load(step_pat(0));
    com_trig = 1'b1; tick(); tick(); tick();
    chk("R4 trigger edge", 32'(gate_out), 32'(step_pat(0)));
    load(step_pat(1)); tick(); tick(); tick();
    chk("R4 held trigger", 32'(gate_out), 32'(step_pat(0)));
    com_trig = 1'b0; tick(); com_trig = 1'b1; tick(); tick(); tick();
    chk("R4 second edge", 32'(gate_out), 32'(step_pat(1)));
    com_trig = 1'b0;

    chk("R10 flag set", 32'(com_flag), 1);
    flag_clr = 1'b1; tick(); flag_clr = 1'b0;
    chk("R10 flag cleared", 32'(com_flag), 0);
    tick();
    chk("R10 flag stays clear", 32'(com_flag), 0);
    sw_com = 1'b1; flag_clr = 1'b1; tick(); sw_com = 1'b0; flag_clr = 1'b0;
    chk("R10 set wins", 32'(com_flag), 1);

    wait_cnt(200);
    cmp_sel = 2'd0; cmp_d = W'(100); cmp_we = 1'b1; tick(); cmp_we = 1'b0;
    cmp_sel = 2'd3; cmp_d = W'(5); cmp_we = 1'b1; tick(); cmp_we = 1'b0;
    wait_cnt(2047);
    chk("R9 old threshold still active", 32'(cmp_hit[0]), 1);
    wait_cnt(100);
    chk("R9 new threshold after update", 32'(cmp_hit[0]), 1);
    wait_cnt(511);
    chk("R9 sel 3 ignored", 32'(cmp_hit[2]), 1);
    wait_cnt(2047);
    chk("R9 old threshold gone", 32'(cmp_hit[0]), 0);
    cmp_sel = 2'd2; cmp_d = W'(3000); cmp_we = 1'b1; tick(); cmp_we = 1'b0;
    fire();
    wait_cnt(3000);
    chk("R9 loaded by commutation", 32'(cmp_hit[2]), 1);

    wait_cnt(10);
    fault_in = 1'b1; tick();
    chk("R7 sync stage 1", 32'(out_en), 1);
    tick();
    chk("R7 sync stage 2", 32'(out_en), 1);
    tick();
    chk("R7 disabled", 32'(out_en), 0);
    chk("R7 idle level", 32'(gate_out), 32'h3F);
    tick(); tick();
    fault_in = 1'b0; tick(); tick(); tick(); tick();
    chk("R8 no early enable", 32'(out_en), 0);
    wait_cnt(PER);
    chk("R8 still off before wrap", 32'(out_en), 0);
    tick();
    chk("R8 enable at update", 32'(out_en), 1);
    chk("R8 pattern restored", 32'(gate_out), 32'(step_pat(1)));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule